// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the host-facing mailbox of an 8042-style keyboard controller. A host bus and an embedded controller exchange bytes through it. The host writes bytes into an inbound register at one of two addresses, one for data and one for commands. The block records which address was used, so the controller can tell a command from data. The controller places bytes for the host in an outbound register. A status byte shows whether each direction holds an unread byte.

The block drives two interrupt lines, one for the keyboard and one for the auxiliary (mouse) device. The controller writes two port bits. Until the controller strobes a one-shot "flags mode", each line simply follows its port bit. Once flags mode is on, the keyboard line shows "outbound full" gated by its port bit, and the auxiliary line shows "inbound empty" gated by its port bit. Flags mode also makes a host read of the outbound data release the outbound-full flag.

Top module: `kbc_mbox`

## Requirements
- R1: A host write with `host_cmd_sel`=0 stores `host_wdata` as the inbound byte. It sets status bit 1 (inbound full) and clears status bit 3 (command marker). The results are visible after the next rising clock edge.
- R2: A host write with `host_cmd_sel`=1 stores the byte, sets status bit 3 and sets status bit 1.
- R3: A controller write (`ctl_out_wr`) stores `ctl_out_data` as the outbound byte and sets status bit 0 (outbound full). The host sees that byte on `host_rdata` while `host_cmd_sel`=0.
- R4: In flags mode, a host read with `host_cmd_sel`=0 clears status bit 0 and drops `kbd_irq` at the same clock edge.
- R5: Outside flags mode, a host read of the data address leaves status bit 0 unchanged.
- R6: `ctl_port_data` bit 0 is the keyboard port bit. In flags mode, `kbd_irq` = status bit 0 AND the keyboard port bit. Outside flags mode, `kbd_irq` equals the keyboard port bit.
- R7: `ctl_port_data` bit 1 is the auxiliary port bit. In flags mode, `aux_irq` = NOT status bit 1 AND the auxiliary port bit. Outside flags mode, `aux_irq` equals the auxiliary port bit.
- R8: After reset, the status byte is 0x00, both interrupt lines are 0, both port bits are 0 and flags mode is off. Status bits 2 and 4 to 7 always read 0.
- R9: A host read with `host_cmd_sel`=1 returns the status byte on `host_rdata` and changes no state.
- R10: A controller read of the inbound byte (`ctl_in_rd`) clears status bit 1.
- R11: Flags mode turns on at a `ctl_flags_set` strobe. It stays on until reset.
- R12: When a set and a clear of the same flag fall in the same cycle, the flag ends up set. This applies to a host write with `ctl_in_rd`, and to `ctl_out_wr` with a host data read in flags mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_cmd_sel | input | 1 | Host address select: 0 data, 1 command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Outbound byte (select 0) or status byte (select 1) |
| ctl_out_wr | input | 1 | Controller write strobe for the outbound byte |
| ctl_out_data | input | 8 | Controller outbound byte |
| ctl_in_rd | input | 1 | Controller read strobe for the inbound byte |
| ctl_in_data | output | 8 | Inbound byte |
| ctl_in_cmd | output | 1 | Inbound byte came from the command address |
| ctl_status | output | 8 | Status byte: bit 0 outbound full, bit 1 inbound full, bit 3 command |
| ctl_flags_set | input | 1 | Strobe that turns flags mode on |
| ctl_port_wr | input | 1 | Port bit write strobe |
| ctl_port_data | input | 2 | Port bits: bit 0 keyboard, bit 1 auxiliary |
| kbd_irq | output | 1 | Keyboard interrupt line |
| aux_irq | output | 1 | Auxiliary interrupt line |

## Verification
The hardest state to reach is flags mode after it has been cleared again. Flags mode can only be left through reset, so the stimulus runs a full flags-mode sequence first. It then pulses reset in the middle of the run. After that it shows that the keyboard line follows its port bit again while the outbound flag is clear. The collision cases also need an exact setup: both colliding strobes are driven in one cycle, and flags mode must already be on for the read-clear to be live.

// File: rtl/kbc_mbox_pkg.sv
package kbc_mbox_pkg;
    localparam int DATA_W    = 8;
    localparam int OBF_POS   = 0;
    localparam int IBF_POS   = 1;
    localparam int CMD_POS   = 3;
    localparam int IRQ_LINES = 2;
    localparam int IRQ_KBD   = 0;
    localparam int IRQ_AUX   = 1;
endpackage

// File: rtl/kbc_mbox_inbox.sv
module kbc_mbox_inbox #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_is_cmd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              ctl_rd,
    output logic [DATA_W-1:0] data_q,
    output logic              cmd_q,
    output logic              full_q,
    output logic              full_nxt
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              cmd;
        logic              full;
    } in_state_t;

    in_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the controller read clears the flag; a host write in the same cycle sets it again
        if (ctl_rd) st_d.full = 1'b0;
        if (host_wr) begin
            st_d.data = host_wdata;
            st_d.cmd  = host_is_cmd;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q   = st_q.data;
    assign cmd_q    = st_q.cmd;
    assign full_q   = st_q.full;
    assign full_nxt = st_d.full;
endmodule

// File: rtl/kbc_mbox_outbox.sv
module kbc_mbox_outbox #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              host_rd,
    input  logic              flags_on,
    output logic [DATA_W-1:0] data_q,
    output logic              full_q,
    output logic              full_nxt
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a host read releases the flag only in flags mode
        if (host_rd && flags_on) st_d.full = 1'b0;
        if (ctl_wr) begin
            st_d.data = ctl_wdata;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q   = st_q.data;
    assign full_q   = st_q.full;
    assign full_nxt = st_d.full;
endmodule

// File: rtl/kbc_mbox_irq.sv
module kbc_mbox_irq
    import kbc_mbox_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flags_set,
    input  logic                 port_wr,
    input  logic [IRQ_LINES-1:0] port_wdata,
    input  logic                 obf_nxt,
    input  logic                 ibf_nxt,
    output logic                 flags_q,
    output logic [IRQ_LINES-1:0] irq_q
);
    typedef struct packed {
        logic                 flags;
        logic [IRQ_LINES-1:0] port;
        logic [IRQ_LINES-1:0] irq;
    } irq_state_t;

    irq_state_t           st_d, st_q;
    logic [IRQ_LINES-1:0] gate_src;

    always_comb begin
        gate_src          = '0;
        gate_src[IRQ_KBD] = obf_nxt;
        gate_src[IRQ_AUX] = ~ibf_nxt;
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = st_q.flags | flags_set;
        if (port_wr) st_d.port = port_wdata;
        for (int i = 0; i < IRQ_LINES; i++) begin
            st_d.irq[i] = st_d.flags ? (gate_src[i] & st_d.port[i]) : st_d.port[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign irq_q   = st_q.irq;
endmodule

// File: rtl/kbc_mbox.sv
module kbc_mbox
    import kbc_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_cmd_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ctl_out_wr,
    input  logic [DATA_W-1:0] ctl_out_data,
    input  logic              ctl_in_rd,
    output logic [DATA_W-1:0] ctl_in_data,
    output logic              ctl_in_cmd,
    output logic [DATA_W-1:0] ctl_status,
    input  logic              ctl_flags_set,
    input  logic              ctl_port_wr,
    input  logic [1:0]        ctl_port_data,
    output logic              kbd_irq,
    output logic              aux_irq
);
    logic              ibf_q, ibf_nxt, obf_q, obf_nxt, cmd_q, flags_on;
    logic [DATA_W-1:0] out_byte;
    logic [IRQ_LINES-1:0] irq_vec;
    logic              host_data_rd;

    assign host_data_rd = host_rd & ~host_cmd_sel;

    kbc_mbox_inbox #(.DATA_W(DATA_W)) u_inbox (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_is_cmd (host_cmd_sel),
        .host_wdata  (host_wdata),
        .ctl_rd      (ctl_in_rd),
        .data_q      (ctl_in_data),
        .cmd_q       (cmd_q),
        .full_q      (ibf_q),
        .full_nxt    (ibf_nxt)
    );

    kbc_mbox_outbox #(.DATA_W(DATA_W)) u_outbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_out_wr),
        .ctl_wdata (ctl_out_data),
        .host_rd   (host_data_rd),
        .flags_on  (flags_on),
        .data_q    (out_byte),
        .full_q    (obf_q),
        .full_nxt  (obf_nxt)
    );

    kbc_mbox_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_set  (ctl_flags_set),
        .port_wr    (ctl_port_wr),
        .port_wdata (ctl_port_data),
        .obf_nxt    (obf_nxt),
        .ibf_nxt    (ibf_nxt),
        .flags_q    (flags_on),
        .irq_q      (irq_vec)
    );

    always_comb begin
        ctl_status          = '0;
        ctl_status[OBF_POS] = obf_q;
        ctl_status[IBF_POS] = ibf_q;
        ctl_status[CMD_POS] = cmd_q;
    end

    assign host_rdata = host_cmd_sel ? ctl_status : out_byte;
    assign ctl_in_cmd = cmd_q;
    assign kbd_irq    = irq_vec[IRQ_KBD];
    assign aux_irq    = irq_vec[IRQ_AUX];
endmodule

// File: rtl/kbc_mbox_checker.sv
module kbc_mbox_checker
    import kbc_mbox_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic              host_cmd_sel,
    input logic [DATA_W-1:0] host_wdata,
    input logic              ctl_out_wr,
    input logic              ctl_in_rd,
    input logic [DATA_W-1:0] ctl_in_data,
    input logic [DATA_W-1:0] ctl_status,
    input logic              ctl_flags_set,
    input logic              flags_on,
    input logic              kbd_irq,
    input logic              aux_irq
);
    assert_data_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && !host_cmd_sel |=> ctl_status[IBF_POS] && !ctl_status[CMD_POS]
                                     && ctl_in_data == $past(host_wdata));

    assert_cmd_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_cmd_sel |=> ctl_status[IBF_POS] && ctl_status[CMD_POS]);

    assert_out_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_out_wr |=> ctl_status[OBF_POS]);

    assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flags_on && host_rd && !host_cmd_sel && !ctl_out_wr |=> !ctl_status[OBF_POS] && !kbd_irq);

    assert_read_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_on && !ctl_flags_set && host_rd && !host_cmd_sel && ctl_status[OBF_POS]
        |=> ctl_status[OBF_POS]);

    assert_kbd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags_on && !ctl_status[OBF_POS] |-> !kbd_irq);

    assert_aux_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_on && ctl_status[IBF_POS] |-> !aux_irq);

    assert_reset_R8: assert property (@(posedge clk)
        !rst_n |=> ctl_status == '0 && !kbd_irq && !aux_irq && !flags_on);

    assert_status_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_cmd_sel && !host_wr && !ctl_out_wr && !ctl_in_rd |=> $stable(ctl_status));

    assert_in_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_in_rd && !host_wr |=> !ctl_status[IBF_POS]);

    assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flags_on |=> flags_on);

    assert_out_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_out_wr && host_rd && !host_cmd_sel |=> ctl_status[OBF_POS]);

    assert_in_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && ctl_in_rd |=> ctl_status[IBF_POS]);
endmodule

bind kbc_mbox kbc_mbox_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_cmd_sel  (host_cmd_sel),
    .host_wdata    (host_wdata),
    .ctl_out_wr    (ctl_out_wr),
    .ctl_in_rd     (ctl_in_rd),
    .ctl_in_data   (ctl_in_data),
    .ctl_status    (ctl_status),
    .ctl_flags_set (ctl_flags_set),
    .flags_on      (flags_on),
    .kbd_irq       (kbd_irq),
    .aux_irq       (aux_irq)
);

// File: tb/kbc_mbox_test.sv
`timescale 1ns/1ps
module kbc_mbox_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 0, host_rd = 0, host_cmd_sel = 0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       ctl_out_wr = 0, ctl_in_rd = 0, ctl_flags_set = 0, ctl_port_wr = 0;
    logic [7:0] ctl_out_data = '0, ctl_in_data, ctl_status;
    logic [1:0] ctl_port_data = '0;
    logic       ctl_in_cmd, kbd_irq, aux_irq;
    int         checks = 0, errors = 0;
    bit         finished = 0;

    always #10 clk = ~clk;

    kbc_mbox uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_cmd_sel(host_cmd_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctl_out_wr(ctl_out_wr), .ctl_out_data(ctl_out_data), .ctl_in_rd(ctl_in_rd),
        .ctl_in_data(ctl_in_data), .ctl_in_cmd(ctl_in_cmd), .ctl_status(ctl_status),
        .ctl_flags_set(ctl_flags_set), .ctl_port_wr(ctl_port_wr),
        .ctl_port_data(ctl_port_data), .kbd_irq(kbd_irq), .aux_irq(aux_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic host_write(input logic cmd, input logic [7:0] b);
        host_wr = 1; host_cmd_sel = cmd; host_wdata = b;
        tick();
        host_wr = 0; host_cmd_sel = 0;
    endtask

    task automatic host_read(input logic cmd);
        host_rd = 1; host_cmd_sel = cmd;
        tick();
        host_rd = 0; host_cmd_sel = 0;
    endtask

    task automatic ctl_write(input logic [7:0] b);
        ctl_out_wr = 1; ctl_out_data = b;
        tick();
        ctl_out_wr = 0;
    endtask

    task automatic ctl_read();
        ctl_in_rd = 1;
        tick();
        ctl_in_rd = 0;
    endtask

    task automatic set_port(input logic [1:0] p);
        ctl_port_wr = 1; ctl_port_data = p;
        tick();
        ctl_port_wr = 0;
    endtask

    task automatic test_reset();
        check("R8 status", ctl_status, 8'h00);
        check("R8 kbd_irq", {7'd0, kbd_irq}, 8'h00);
        check("R8 aux_irq", {7'd0, aux_irq}, 8'h00);
    endtask

    task automatic test_data_write();
        host_write(1'b0, 8'h5A);
        check("R1 in byte", ctl_in_data, 8'h5A);
        check("R1 cmd flag", {7'd0, ctl_in_cmd}, 8'h00);
        check("R1 status", ctl_status, 8'h02);
    endtask

    task automatic test_status_read();
        host_cmd_sel = 1; #1;
        check("R9 status on host_rdata", host_rdata, 8'h02);
        host_cmd_sel = 0;
        host_read(1'b1);
        check("R9 no side effect", ctl_status, 8'h02);
    endtask

    task automatic test_ctl_read();
        ctl_read();
        check("R10 ibf cleared", ctl_status, 8'h00);
    endtask

    task automatic test_cmd_write();
        host_write(1'b1, 8'hD1);
        check("R2 in byte", ctl_in_data, 8'hD1);
        check("R2 status", ctl_status, 8'h0A);
        ctl_read();
        check("R10 ibf cleared after cmd", ctl_status, 8'h08);
    endtask

    task automatic test_ports_direct();
        set_port(2'b10);
        check("R7 aux follows port", {7'd0, aux_irq}, 8'h01);
        check("R6 kbd follows port", {7'd0, kbd_irq}, 8'h00);
        set_port(2'b01);
        check("R6 kbd follows port high", {7'd0, kbd_irq}, 8'h01);
        check("R7 aux follows port low", {7'd0, aux_irq}, 8'h00);
    endtask

    task automatic test_out_write_no_flags();
        ctl_write(8'h3C);
        check("R3 obf", ctl_status & 8'h01, 8'h01);
        #1;
        check("R3 host sees byte", host_rdata, 8'h3C);
        host_read(1'b0);
        check("R5 obf kept", ctl_status & 8'h01, 8'h01);
    endtask

    task automatic test_flags_mode();
        set_port(2'b11);
        ctl_flags_set = 1; tick(); ctl_flags_set = 0;
        check("R11 R6 kbd gated by obf", {7'd0, kbd_irq}, 8'h01);
        check("R7 aux high when inbox empty", {7'd0, aux_irq}, 8'h01);
        host_write(1'b0, 8'h11);
        check("R7 aux low when inbox full", {7'd0, aux_irq}, 8'h00);
        ctl_read();
        check("R7 aux back high", {7'd0, aux_irq}, 8'h01);
        host_read(1'b0);
        check("R4 obf cleared", ctl_status & 8'h01, 8'h00);
        check("R4 kbd dropped", {7'd0, kbd_irq}, 8'h00);
        set_port(2'b10);
        ctl_write(8'h77);
        check("R6 kbd masked by port", {7'd0, kbd_irq}, 8'h00);
        set_port(2'b11);
        check("R6 kbd on with port", {7'd0, kbd_irq}, 8'h01);
    endtask

    task automatic test_collisions();
        host_rd = 1; host_cmd_sel = 0; ctl_out_wr = 1; ctl_out_data = 8'hA5;
        tick();
        host_rd = 0; ctl_out_wr = 0;
        check("R12 obf set wins", ctl_status & 8'h01, 8'h01);
        #1;
        check("R12 new out byte", host_rdata, 8'hA5);
        host_wr = 1; host_cmd_sel = 0; host_wdata = 8'h42; ctl_in_rd = 1;
        tick();
        host_wr = 0; ctl_in_rd = 0;
        check("R12 ibf set wins", ctl_status & 8'h02, 8'h02);
        ctl_read();
    endtask

    task automatic test_sticky_and_reset();
        repeat (5) tick();
        host_read(1'b0);
        check("R11 still in flags mode", ctl_status & 8'h01, 8'h00);
        rst_n = 0; tick(); rst_n = 1; tick();
        test_reset();
        set_port(2'b01);
        check("R11 mode off after reset", {7'd0, kbd_irq}, 8'h01);
        ctl_write(8'h12);
        host_read(1'b0);
        check("R11 R5 no clear after reset", ctl_status & 8'h01, 8'h01);
    endtask

    initial begin
        repeat (2) tick();
        rst_n = 1;
        tick();
        test_reset();
        test_data_write();
        test_status_read();
        test_ctl_read();
        test_cmd_write();
        test_ports_direct();
        test_out_write_no_flags();
        test_flags_mode();
        test_collisions();
        test_sticky_and_reset();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule